// File: doc/BRIEF.md
# Multiplexed Parallel ADC Sequencer

This block is a synchronous controller for an external eight-input, 8-bit successive-approximation converter that returns its result on a parallel bus with tri-state outputs. For each conversion it drives the channel number onto three select lines and pulses the address strobe so the converter latches that channel. It then pulses the conversion start. Next it waits for the converter's completion line to fall and rise again. Finally it enables the converter's outputs, samples the byte, and releases the bus.

Each result leaves the block as a one-cycle valid strobe that carries the data byte and the channel it came from. A request converts one channel and then returns to idle. If the scan input is high when the request is taken, the block instead steps through the channels in a loop, wrapping from 7 back to 0, for as long as scan stays high. A programmable timeout guards both halves of the completion handshake.

Top module: `adcseq_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters idle. In the following cycle `adc_ale_o`, `adc_start_o`, `adc_oe_o`, `busy_o`, `res_valid_o` and `err_o` are all low.
- R2: When a request is accepted, `adc_addr_o` carries the requested channel for SETUP_CYC cycles with the strobe low. `adc_ale_o` is then high for ALE_CYC cycles. The address does not change from the setup phase until the conversion is read.
- R3: After `adc_ale_o` falls, GAP_CYC cycles pass with all strobes low. `adc_start_o` is then high for START_CYC cycles.
- R4: `adc_eoc_i` passes through a two-stage synchronizer. After the start pulse ends, the block first waits for the synchronized level to be low and then for it to be high. A completion line that is still high just after start is never taken as completion.
- R5: `adc_oe_o` is high only during the read window: exactly SAMPLE_DLY cycles, starting the cycle after the synchronized completion line is seen high. At most one of `adc_ale_o`, `adc_start_o` and `adc_oe_o` is high in any cycle.
- R6: `adc_data_i` is sampled at the last clock edge of the read window. In the next cycle `res_valid_o` is high for exactly one cycle, with `res_data_o` holding that byte and `res_ch_o` holding the channel that was converted.
- R7: In scan mode, the cycle that shows `res_valid_o` also begins the setup of the next conversion, with `adc_addr_o` equal to `res_ch_o + 1` modulo 8.
- R8: A wait phase times out if its condition is still unmet in the cycle where its counter equals `timeout_i`, that is after `timeout_i + 1` cycles in that phase. The block then returns to idle and raises `err_o` for one cycle with `busy_o` low. No result is produced. If the condition is met in that same cycle, the condition wins.
- R9: In single mode, the block returns to idle after the result (`busy_o` low). A `req_i` seen while busy is ignored.
- R10: If `scan_i` is low in the cycle the read window ends, scanning stops after that result and the block goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request a conversion (taken only when idle) |
| req_ch_i | input | 3 | Channel for the request, or the first channel of a scan |
| scan_i | input | 1 | Scan mode select; looping continues while high |
| timeout_i | input | 16 | Wait-phase limit in cycles, minus one |
| adc_eoc_i | input | 1 | Converter completion line (asynchronous) |
| adc_data_i | input | 8 | Converter parallel result bus |
| adc_addr_o | output | 3 | Channel select lines |
| adc_ale_o | output | 1 | Address latch strobe |
| adc_start_o | output | 1 | Conversion start pulse |
| adc_oe_o | output | 1 | Converter output enable |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_ch_o | output | 3 | Channel tag of the result |
| res_data_o | output | 8 | Result byte |
| busy_o | output | 1 | Sequencer not idle |
| err_o | output | 1 | One-cycle timeout flag |

## Verification
Two pairs of events can fall in the same cycle. The first pair is an edge of the synchronized completion line and the expiry of the timeout. The bench provokes this by sweeping the delay of the converter model across a small fixed timeout, so that one setting makes the edge arrive exactly in the cycle the counter reaches its limit. The per-cycle reference model decides that the handshake proceeds and no error is flagged. The second pair, in scan mode, is the result strobe and the setup of the next channel. Here the bench checks that the address lines already show the next channel while `res_ch_o` still tags the previous one, and that the wrap from 7 to 0 behaves the same way.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    // Sequencer phases, in the order a conversion visits them.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_ALE   = 3'd2,
        ST_GAP   = 3'd3,
        ST_START = 3'd4,
        ST_WFALL = 3'd5,
        ST_WRISE = 3'd6,
        ST_READ  = 3'd7
    } seq_state_e;

endpackage

// File: rtl/adcseq_sync.sv
module adcseq_sync #(
    parameter int  STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= RESET_VAL;
                    else        chain_q[g] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= RESET_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/adcseq_phase_cmp.sv
module adcseq_phase_cmp
    import adcseq_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int SETUP_CYC  = 2,
    parameter int ALE_CYC    = 3,
    parameter int GAP_CYC    = 2,
    parameter int START_CYC  = 3,
    parameter int SAMPLE_DLY = 3
) (
    input  seq_state_e       st_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] timeout_i,
    output logic             last_o,
    output logic             expired_o
);

    localparam logic [CNT_W-1:0] SETUP_LAST  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] ALE_LAST    = CNT_W'(ALE_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LAST    = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] START_LAST  = CNT_W'(START_CYC - 1);
    localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_DLY - 1);

    logic [CNT_W-1:0] lim;

    always_comb begin
        unique case (st_i)
            ST_SETUP: lim = SETUP_LAST;
            ST_ALE:   lim = ALE_LAST;
            ST_GAP:   lim = GAP_LAST;
            ST_START: lim = START_LAST;
            ST_READ:  lim = SAMPLE_LAST;
            default:  lim = '0;
        endcase
    end

    assign last_o    = (cnt_i == lim);
    assign expired_o = (cnt_i == timeout_i);

endmodule

// File: rtl/adcseq_chan_step.sv
module adcseq_chan_step #(
    parameter int CH_W = 3
) (
    input  logic [CH_W-1:0] ch_i,
    output logic [CH_W-1:0] nxt_o
);

    // Natural wrap of the CH_W-bit sum gives the modulo-(2**CH_W) step.
    assign nxt_o = ch_i + CH_W'(1);

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int CH_W        = 3,
    parameter int DATA_W      = 8,
    parameter int TO_W        = 16,
    parameter int SETUP_CYC   = 2,
    parameter int ALE_CYC     = 3,
    parameter int GAP_CYC     = 2,
    parameter int START_CYC   = 3,
    parameter int SAMPLE_DLY  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [CH_W-1:0]   req_ch_i,
    input  logic              scan_i,
    input  logic [TO_W-1:0]   timeout_i,
    input  logic              adc_eoc_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic [CH_W-1:0]   adc_addr_o,
    output logic              adc_ale_o,
    output logic              adc_start_o,
    output logic              adc_oe_o,
    output logic              res_valid_o,
    output logic [CH_W-1:0]   res_ch_o,
    output logic [DATA_W-1:0] res_data_o,
    output logic              busy_o,
    output logic              err_o
);

    localparam int CNT_W = TO_W;

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [CH_W-1:0]   ch;
        logic              scan;
        logic [DATA_W-1:0] data;
        logic [CH_W-1:0]   tag;
        logic              valid;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;

    logic             eoc_s;
    logic             last;
    logic             expired;
    logic [CH_W-1:0]  ch_next;
    logic [CNT_W-1:0] cnt_inc;

    adcseq_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (adc_eoc_i),
        .sync_o  (eoc_s)
    );

    adcseq_phase_cmp #(
        .CNT_W      (CNT_W),
        .SETUP_CYC  (SETUP_CYC),
        .ALE_CYC    (ALE_CYC),
        .GAP_CYC    (GAP_CYC),
        .START_CYC  (START_CYC),
        .SAMPLE_DLY (SAMPLE_DLY)
    ) u_cmp (
        .st_i      (r_q.st),
        .cnt_i     (r_q.cnt),
        .timeout_i (timeout_i),
        .last_o    (last),
        .expired_o (expired)
    );

    adcseq_chan_step #(
        .CH_W (CH_W)
    ) u_step (
        .ch_i  (r_q.ch),
        .nxt_o (ch_next)
    );

    assign cnt_inc = r_q.cnt + CNT_W'(1);

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.err   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    r_d.st   = ST_SETUP;
                    r_d.ch   = req_ch_i;
                    r_d.scan = scan_i;
                    r_d.cnt  = '0;
                end
            end
            ST_SETUP: begin
                if (last) begin
                    r_d.st  = ST_ALE;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = cnt_inc;
                end
            end
            ST_ALE: begin
                if (last) begin
                    r_d.st  = ST_GAP;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = cnt_inc;
                end
            end
            ST_GAP: begin
                if (last) begin
                    r_d.st  = ST_START;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = cnt_inc;
                end
            end
            ST_START: begin
                if (last) begin
                    r_d.st  = ST_WFALL;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = cnt_inc;
                end
            end
            ST_WFALL: begin
                if (!eoc_s) begin
                    r_d.st  = ST_WRISE;
                    r_d.cnt = '0;
                end else if (expired) begin
                    r_d.st  = ST_IDLE;
                    r_d.err = 1'b1;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = cnt_inc;
                end
            end
            ST_WRISE: begin
                if (eoc_s) begin
                    r_d.st  = ST_READ;
                    r_d.cnt = '0;
                end else if (expired) begin
                    r_d.st  = ST_IDLE;
                    r_d.err = 1'b1;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = cnt_inc;
                end
            end
            ST_READ: begin
                if (last) begin
                    r_d.valid = 1'b1;
                    r_d.data  = adc_data_i;
                    r_d.tag   = r_q.ch;
                    r_d.cnt   = '0;
                    if (r_q.scan && scan_i) begin
                        r_d.st = ST_SETUP;
                        r_d.ch = ch_next;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end else begin
                    r_d.cnt = cnt_inc;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign adc_addr_o  = r_q.ch;
    assign adc_ale_o   = (r_q.st == ST_ALE);
    assign adc_start_o = (r_q.st == ST_START);
    assign adc_oe_o    = (r_q.st == ST_READ);
    assign res_valid_o = r_q.valid;
    assign res_ch_o    = r_q.tag;
    assign res_data_o  = r_q.data;
    assign busy_o      = (r_q.st != ST_IDLE);
    assign err_o       = r_q.err;

endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
    parameter int CH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            eoc_s,
    input logic [CH_W-1:0] adc_addr_o,
    input logic            adc_ale_o,
    input logic            adc_start_o,
    input logic            adc_oe_o,
    input logic            res_valid_o,
    input logic [CH_W-1:0] res_ch_o,
    input logic            busy_o,
    input logic            err_o
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!adc_ale_o && !adc_start_o && !adc_oe_o && !busy_o && !res_valid_o && !err_o));

    assert_addr_hold_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_ale_o) |-> $stable(adc_addr_o));

    assert_addr_hold_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_ale_o) |-> $stable(adc_addr_o));

    assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({adc_ale_o, adc_start_o, adc_oe_o}));

    assert_read_after_eoc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_oe_o) |-> $past(eoc_s));

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    assert_valid_ends_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $fell(adc_oe_o));

    assert_scan_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && busy_o) |-> (adc_addr_o == CH_W'(res_ch_o + CH_W'(1))));

    assert_timeout_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!busy_o && !res_valid_o));

endmodule

bind adcseq_top adcseq_chk #(.CH_W(CH_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .eoc_s       (eoc_s),
    .adc_addr_o  (adc_addr_o),
    .adc_ale_o   (adc_ale_o),
    .adc_start_o (adc_start_o),
    .adc_oe_o    (adc_oe_o),
    .res_valid_o (res_valid_o),
    .res_ch_o    (res_ch_o),
    .busy_o      (busy_o),
    .err_o       (err_o)
);

// File: tb/tb_adcseq_top.sv
module tb_adcseq_top;

    localparam int SETUP_CYC  = 2;
    localparam int ALE_CYC    = 3;
    localparam int GAP_CYC    = 2;
    localparam int START_CYC  = 3;
    localparam int SAMPLE_DLY = 3;
    localparam int NCH        = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [2:0]  req_ch_i = '0;
    logic        scan_i = 1'b0;
    logic [15:0] timeout_i = 16'd40;
    logic        adc_eoc = 1'b1;
    logic [7:0]  adc_data;
    logic [2:0]  adc_addr_o;
    logic        adc_ale_o, adc_start_o, adc_oe_o;
    logic        res_valid_o, busy_o, err_o;
    logic [2:0]  res_ch_o;
    logic [7:0]  res_data_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    adcseq_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .req_ch_i    (req_ch_i),
        .scan_i      (scan_i),
        .timeout_i   (timeout_i),
        .adc_eoc_i   (adc_eoc),
        .adc_data_i  (adc_data),
        .adc_addr_o  (adc_addr_o),
        .adc_ale_o   (adc_ale_o),
        .adc_start_o (adc_start_o),
        .adc_oe_o    (adc_oe_o),
        .res_valid_o (res_valid_o),
        .res_ch_o    (res_ch_o),
        .res_data_o  (res_data_o),
        .busy_o      (busy_o),
        .err_o       (err_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Converter model: latches the channel on the strobe's falling edge,
    // drops completion d1 cycles after start ends, raises it d2 cycles later.
    int       emu_d1 = 4, emu_d2 = 10, emu_seq = 0;
    bit       emu_busy = 0, emu_expect = 1;
    logic [7:0] emu_val = 8'h00;
    logic [2:0] lat_ch = '0;
    int       exp_ch[$];
    int       exp_dat[$];

    assign adc_data = adc_oe_o ? emu_val : 8'hzz;

    initial begin
        bit ale_p = 0, st_p = 0;
        forever begin
            @(negedge clk);
            if (ale_p && !adc_ale_o) lat_ch = adc_addr_o;
            if (st_p && !adc_start_o) begin
                emu_busy = 1;
                repeat (emu_d1) @(negedge clk);
                adc_eoc = 1'b0;
                repeat (emu_d2) @(negedge clk);
                emu_seq++;
                emu_val = 8'((int'(lat_ch) * 29 + emu_seq * 7 + 1) % 256);
                if (emu_expect) begin
                    exp_ch.push_back(int'(lat_ch));
                    exp_dat.push_back(int'(emu_val));
                end
                adc_eoc = 1'b1;
                emu_busy = 0;
            end
            ale_p = adc_ale_o;
            st_p  = adc_start_o;
        end
    end

    // Input samples taken well away from either clock edge.
    logic       s_req, s_scan, s_eoc, s_rst;
    logic [2:0] s_ch;
    logic [7:0] s_dat;
    int         s_tmo;
    always @(negedge clk) begin
        #5;
        s_req = req_i; s_scan = scan_i; s_eoc = adc_eoc; s_rst = rst_n;
        s_ch = req_ch_i; s_dat = adc_data; s_tmo = int'(timeout_i);
    end

    // Behavioural per-cycle reference: phases 0 idle,1 setup,2 strobe,3 gap,
    // 4 start,5 wait low,6 wait high,7 read.
    int  m_ph = 0, m_cnt = 0, m_ch = 0, m_tag = 0, m_dat = 0;
    bit  m_scan = 0, m_valid = 0, m_err = 0, m_s1 = 1, m_s2 = 1;

    function automatic int plen(input int ph);
        case (ph)
            1: return SETUP_CYC;
            2: return ALE_CYC;
            3: return GAP_CYC;
            4: return START_CYC;
            default: return SAMPLE_DLY;
        endcase
    endfunction

    always @(posedge clk) begin
        m_valid = 0; m_err = 0;
        if (!s_rst) begin
            m_ph = 0; m_cnt = 0; m_ch = 0; m_tag = 0; m_dat = 0; m_scan = 0;
            m_s1 = 1; m_s2 = 1;
        end else begin
            case (m_ph)
                0: if (s_req) begin m_ph = 1; m_ch = int'(s_ch); m_scan = s_scan; m_cnt = 0; end
                1, 2, 3, 4: begin
                    if (m_cnt == plen(m_ph) - 1) begin m_ph++; m_cnt = 0; end
                    else m_cnt++;
                end
                5: begin
                    if (!m_s2) begin m_ph = 6; m_cnt = 0; end
                    else if (m_cnt == s_tmo) begin m_ph = 0; m_err = 1; m_cnt = 0; end
                    else m_cnt++;
                end
                6: begin
                    if (m_s2) begin m_ph = 7; m_cnt = 0; end
                    else if (m_cnt == s_tmo) begin m_ph = 0; m_err = 1; m_cnt = 0; end
                    else m_cnt++;
                end
                default: begin
                    if (m_cnt == SAMPLE_DLY - 1) begin
                        m_valid = 1; m_dat = int'(s_dat); m_tag = m_ch; m_cnt = 0;
                        if (m_scan && s_scan) begin m_ph = 1; m_ch = (m_ch + 1) % NCH; end
                        else m_ph = 0;
                    end else m_cnt++;
                end
            endcase
            m_s2 = m_s1;
            m_s1 = s_eoc;
        end
    end

    bit sb_on = 1;
    int n_err = 0, n_valid = 0, n_ale = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 address", int'(adc_addr_o), m_ch);
            check("R2 strobe", int'(adc_ale_o), int'(m_ph == 2));
            check("R3 start", int'(adc_start_o), int'(m_ph == 4));
            check("R4/R5 output enable", int'(adc_oe_o), int'(m_ph == 7));
            check("R9 busy", int'(busy_o), int'(m_ph != 0));
            check("R6 valid", int'(res_valid_o), int'(m_valid));
            check("R6 tag", int'(res_ch_o), m_tag);
            check("R6 data", int'(res_data_o), m_dat);
            check("R8 error", int'(err_o), int'(m_err));
            if (err_o) n_err++;
            if (res_valid_o) n_valid++;
            if (adc_ale_o && !$past(adc_ale_o)) n_ale++;
            if (res_valid_o && sb_on) begin
                if (exp_ch.size() == 0) check("R6 unexpected result", 1, 0);
                else begin
                    check("R6/R7 scoreboard channel", int'(res_ch_o), exp_ch.pop_front());
                    check("R6 scoreboard data", int'(res_data_o), exp_dat.pop_front());
                end
            end
            if (res_valid_o && busy_o)
                check("R7 next address", int'(adc_addr_o), (int'(res_ch_o) + 1) % NCH);
        end
    end

    task automatic settle();
        do @(negedge clk); while (busy_o || emu_busy);
        repeat (3) @(negedge clk);
    endtask

    task automatic request(input int ch, input bit scan);
        @(negedge clk);
        req_ch_i = 3'(ch); scan_i = scan; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 strobe", int'(adc_ale_o), 0);
        check("R1 start", int'(adc_start_o), 0);
        check("R1 oe", int'(adc_oe_o), 0);
        check("R1 busy", int'(busy_o), 0);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R6 R9: single conversions, with completion still high after start
        emu_d1 = 4; emu_d2 = 10;
        request(5, 0);
        settle();
        check("R9 single done count", n_valid, 1);
        emu_d1 = 1; emu_d2 = 3;
        request(0, 0);
        repeat (6) @(negedge clk);
        req_ch_i = 3'd2; req_i = 1'b1;          // R9: ignored while busy
        @(negedge clk); req_i = 1'b0;
        settle();
        n_ale = 0;
        repeat (30) @(negedge clk);
        check("R9 no extra conversion", n_ale, 0);
        check("R9 result count", n_valid, 2);

        // R7 R10: scan from channel 6 across the wrap, then stop
        emu_d1 = 2; emu_d2 = 6;
        n_valid = 0;
        request(6, 1);
        do @(negedge clk); while (n_valid < 4);
        scan_i = 1'b0;
        settle();
        check("R10 scan stopped count", n_valid, 5);
        check("R7 queue drained", exp_ch.size(), 0);

        // R8: completion never falls within the limit
        timeout_i = 16'd20; emu_expect = 0; n_err = 0; n_valid = 0;
        emu_d1 = 60; emu_d2 = 5;
        request(3, 0);
        settle();
        check("R8 timeout on fall", n_err, 1);
        check("R8 no result", n_valid, 0);
        // R8: completion never rises within the limit
        emu_d1 = 2; emu_d2 = 60; n_err = 0;
        request(4, 0);
        settle();
        check("R8 timeout on rise", n_err, 1);
        check("R8 no result after rise timeout", n_valid, 0);

        // R8 boundary: sweep edge timing across a small limit
        sb_on = 0; timeout_i = 16'd6; emu_d2 = 3;
        for (int d = 4; d <= 10; d++) begin
            emu_d1 = d;
            request(d % NCH, 0);
            settle();
        end
        sb_on = 1; emu_expect = 1; exp_ch.delete(); exp_dat.delete();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule